// File: doc/BRIEF.md
# Retransmit-Once Reassembly Controller

This block sits at the receiving end of a network that never buffers packets in flight. Multi-flit packets arrive flit by flit, in any order, each flit carrying its source, a request ID, its own sequence number and the sequence number of the packet's last flit. Senders always transmit a packet without first reserving space. The controller owns a small pool of reassembly slots. The first flit of an unknown packet claims the lowest free slot, and each flit sets the bit of its sequence number in that slot's received mask. When the mask covers every sequence number from zero to the last, the controller reports completion with the slot index. A completed slot stays held until the requester releases it.

When a flit of an unknown packet finds every slot occupied, the flit is discarded and the packet's source and request ID are recorded once in a pending FIFO. When a held slot is released while that FIFO is not empty, the slot goes at once to the oldest pending packet and a retransmit request naming its source and request ID is offered on a valid/ready port. Because the space already waits for it, each dropped packet is resent exactly once.

Each slot runs its own state machine with four states. FREE goes to FILL on allocation (or straight to HELD for a packet complete in one flit). WAIT goes to FILL on its first retransmitted flit. FILL goes to HELD on completion. HELD goes to WAIT on a release that finds a pending packet, to FILL or HELD on a release that is reused in the same cycle by a new packet, and otherwise to FREE. The retransmit port has two named conditions: open (free to show the lowest owed slot) and locked (held on the slot shown while the consumer stalls).

Top module: `rtx_once_rx`

## Requirements
- R1: After reset all slots are FREE, and `done_valid` and `retx_valid` are low.
- R2: A flit that matches no occupied slot and no pending entry claims the lowest-index free slot. Flits are placed by `flit_seq` in any arrival order. In the cycle after the flit that completes the packet (bits 0 to `flit_last` all received), `done_valid` pulses for one cycle with the slot index, source and request ID.
- R3: A packet with `flit_last` = 0 completes on its only flit and is reported in the next cycle.
- R4: A flit of an unknown packet that finds no free slot is discarded with no completion and no retransmit request. Its source and request ID are pushed once onto the pending FIFO; later flits of the same packet are discarded without a second entry.
- R5: A release of a held slot while the pending FIFO is not empty reserves that slot for the oldest pending packet. No new packet can take the slot, and `retx_valid` rises in the next cycle with that packet's source and request ID.
- R6: Retransmitted flits are matched to their reserved slot by source and request ID, and they complete there.
- R7: A release is honoured only for a HELD slot whose retransmit request has already been handed off. A release aimed at any other slot is ignored, and a packet filling that slot still completes there.
- R8: While `retx_valid` is high and `retx_ready` is low, `retx_src` and `retx_req` do not change. At most one request is handed off per cycle.
- R9: Flits that match a slot already HELD are absorbed: no slot is claimed and no second completion is reported.
- R10: When the pending FIFO is empty, a release and a flit of a new packet in the same cycle let the new packet claim the slot being released.
- R11: Each dropped packet gets exactly one retransmit request, however many of its flits were discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | A flit is present this cycle |
| flit_src | input | SRC_W | Source node of the flit |
| flit_req | input | REQ_W | Request ID of the flit's packet |
| flit_seq | input | SEQ_W | Sequence number of this flit |
| flit_last | input | SEQ_W | Sequence number of the packet's last flit |
| rel_valid | input | 1 | Requester releases a slot |
| rel_slot | input | SLOT_W | Index of the slot being released |
| done_valid | output | 1 | Completion strobe |
| done_slot | output | SLOT_W | Slot that completed |
| done_src | output | SRC_W | Source of the completed packet |
| done_req | output | REQ_W | Request ID of the completed packet |
| retx_valid | output | 1 | Retransmit request offered |
| retx_ready | input | 1 | Consumer accepts the retransmit request |
| retx_src | output | SRC_W | Source to ask for a resend |
| retx_req | output | REQ_W | Request ID to resend |

## Verification
The assertions check four rules on every cycle: a non-empty pending FIFO never leaves a slot free, no two slots track the same packet, a stalled retransmit request holds its fields, and a completion names a slot that is not free. Only the bench scenarios can show ordering across whole transactions. These include the oldest pending packet receiving the first released slot, each dropped packet getting exactly one retransmit request, a premature release being ignored, and a release being reused in the same cycle. A behavioural reference model, compared against the design on every clock, confirms each completion and each offered request.

// File: rtl/rsm_pkg.sv
`timescale 1ns/1ps
package rsm_pkg;
    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_FILL = 2'd1,
        SL_WAIT = 2'd2,
        SL_HELD = 2'd3
    } slot_st_e;
endpackage

// File: rtl/rsm_lowest.sv
`timescale 1ns/1ps
// Finds the lowest set bit of a request vector.
module rsm_lowest #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rsm_pend.sv
`timescale 1ns/1ps
// FIFO of dropped packet keys, with a search port for duplicates.
module rsm_pend #(
    parameter int W     = 7,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_key,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    input  logic [W-1:0] probe,
    output logic         probe_hit
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] rd_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok;
    logic [PW-1:0] wr_idx;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign head    = mem_q[rd_q];
    assign push_ok = push && (!full || pop);
    assign wr_idx  = PW'((int'(rd_q) + int'(cnt_q)) % DEPTH);

    always_comb begin
        probe_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cnt_q && mem_q[PW'((int'(rd_q) + i) % DEPTH)] == probe)
                probe_hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (push_ok) mem_q[wr_idx] <= push_key;
            if (pop && !empty) rd_q <= PW'((int'(rd_q) + 1) % DEPTH);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop && !empty);
        end
    end
endmodule

// File: rtl/rsm_slot.sv
`timescale 1ns/1ps
// One reassembly slot: owner key, received mask and lifecycle state.
module rsm_slot
    import rsm_pkg::*;
#(
    parameter int SRC_W = 4,
    parameter int REQ_W = 3,
    parameter int SEQ_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_src,
    input  logic [REQ_W-1:0] in_req,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic [SEQ_W-1:0] in_last,
    input  logic             alloc,
    input  logic             release_go,
    input  logic             reserve,
    input  logic [SRC_W-1:0] rsv_src,
    input  logic [REQ_W-1:0] rsv_req,
    input  logic             sent,
    output logic             hit,
    output logic             is_free,
    output logic             is_held,
    output logic             owed,
    output logic             finish,
    output logic [SRC_W-1:0] cur_src,
    output logic [REQ_W-1:0] cur_req
);
    localparam int NFL = 1 << SEQ_W;

    slot_st_e         st_q, st_d;
    logic [SRC_W-1:0] src_q, src_d;
    logic [REQ_W-1:0] req_q, req_d;
    logic [NFL-1:0]   mask_q, mask_d;
    logic             owed_q, owed_d;

    logic [NFL-1:0] seq_bit, merged, fresh, need;

    function automatic logic [NFL-1:0] span(input logic [SEQ_W-1:0] l);
        logic [NFL-1:0] m;
        m = '0;
        for (int i = 0; i < NFL; i++) m[i] = (i <= int'(l));
        return m;
    endfunction

    assign seq_bit = {{(NFL-1){1'b0}}, 1'b1} << in_seq;
    assign merged  = mask_q | seq_bit;
    assign fresh   = seq_bit;
    assign need    = span(in_last);

    assign hit     = in_valid && (st_q != SL_FREE) && (src_q == in_src) && (req_q == in_req);
    assign is_free = (st_q == SL_FREE);
    assign is_held = (st_q == SL_HELD) && !owed_q;
    assign owed    = owed_q;
    assign cur_src = src_q;
    assign cur_req = req_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SL_FREE;
            src_q  <= '0;
            req_q  <= '0;
            mask_q <= '0;
            owed_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            src_q  <= src_d;
            req_q  <= req_d;
            mask_q <= mask_d;
            owed_q <= owed_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d   = st_q;
        src_d  = src_q;
        req_d  = req_q;
        mask_d = mask_q;
        owed_d = owed_q;
        finish = 1'b0;
        if (sent) owed_d = 1'b0;
        unique case (st_q)
            SL_FREE: begin
                if (alloc) begin
                    src_d  = in_src;
                    req_d  = in_req;
                    mask_d = fresh;
                    finish = (fresh == need);
                    st_d   = finish ? SL_HELD : SL_FILL;
                end
            end
            SL_FILL, SL_WAIT: begin
                if (hit) begin
                    mask_d = merged;
                    finish = (merged == need);
                    st_d   = finish ? SL_HELD : SL_FILL;
                end
            end
            SL_HELD: begin
                if (release_go) begin
                    if (reserve) begin
                        src_d  = rsv_src;
                        req_d  = rsv_req;
                        mask_d = '0;
                        owed_d = 1'b1;
                        st_d   = SL_WAIT;
                    end else if (alloc) begin
                        src_d  = in_src;
                        req_d  = in_req;
                        mask_d = fresh;
                        finish = (fresh == need);
                        st_d   = finish ? SL_HELD : SL_FILL;
                    end else begin
                        mask_d = '0;
                        st_d   = SL_FREE;
                    end
                end
            end
            default: st_d = SL_FREE;
        endcase
    end
endmodule

// File: rtl/rtx_once_rx.sv
`timescale 1ns/1ps
// Receiver-side reassembly slot manager with retransmit-once recovery.
module rtx_once_rx #(
    parameter int NSLOT      = 4,
    parameter int SRC_W      = 4,
    parameter int REQ_W      = 3,
    parameter int SEQ_W      = 2,
    parameter int PEND_DEPTH = 4,
    parameter int SLOT_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flit_valid,
    input  logic [SRC_W-1:0]  flit_src,
    input  logic [REQ_W-1:0]  flit_req,
    input  logic [SEQ_W-1:0]  flit_seq,
    input  logic [SEQ_W-1:0]  flit_last,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    output logic              done_valid,
    output logic [SLOT_W-1:0] done_slot,
    output logic [SRC_W-1:0]  done_src,
    output logic [REQ_W-1:0]  done_req,
    output logic              retx_valid,
    input  logic              retx_ready,
    output logic [SRC_W-1:0]  retx_src,
    output logic [REQ_W-1:0]  retx_req
);
    localparam int KEY_W = SRC_W + REQ_W;

    logic [NSLOT-1:0] hit_vec, free_vec, held_vec, owed_vec, fin_vec;
    logic [NSLOT-1:0] alloc_vec, sent_vec, rel_onehot, free_eff;
    logic [SRC_W-1:0] slot_src [NSLOT];
    logic [REQ_W-1:0] slot_req [NSLOT];

    logic             rel_ok, reserve_now, new_pkt, in_pend, push;
    logic             pend_empty, pend_full;
    logic [KEY_W-1:0] pend_head;
    logic             alloc_any, pick_any, fin_any;
    logic [SLOT_W-1:0] alloc_idx, pick_idx, fin_idx, sel;

    logic              lock_q, lock_d;
    logic [SLOT_W-1:0] sel_q;
    logic              dv_q, dv_d;
    logic [SLOT_W-1:0] ds_q, ds_d;
    logic [SRC_W-1:0]  dsrc_q, dsrc_d;
    logic [REQ_W-1:0]  dreq_q, dreq_d;

    // Release and allocation decisions
    assign rel_ok      = rel_valid && held_vec[rel_slot];
    assign rel_onehot  = rel_ok ? (NSLOT'(1) << rel_slot) : '0;
    assign reserve_now = rel_ok && !pend_empty;
    assign free_eff    = free_vec | (pend_empty ? rel_onehot : '0);
    assign new_pkt     = flit_valid && !(|hit_vec) && !in_pend;
    assign push        = new_pkt && !alloc_any;

    rsm_lowest #(.N(NSLOT), .IW(SLOT_W)) u_alloc_pick (
        .req(free_eff), .any(alloc_any), .idx(alloc_idx)
    );

    rsm_pend #(.W(KEY_W), .DEPTH(PEND_DEPTH)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_key({flit_src, flit_req}),
        .pop(reserve_now), .head(pend_head),
        .empty(pend_empty), .full(pend_full),
        .probe({flit_src, flit_req}), .probe_hit(in_pend)
    );

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            assign alloc_vec[g] = new_pkt && alloc_any && (alloc_idx == SLOT_W'(g));
            assign sent_vec[g]  = retx_valid && retx_ready && (sel == SLOT_W'(g));
            rsm_slot #(.SRC_W(SRC_W), .REQ_W(REQ_W), .SEQ_W(SEQ_W)) u_slot (
                .clk(clk), .rst_n(rst_n),
                .in_valid(flit_valid), .in_src(flit_src), .in_req(flit_req),
                .in_seq(flit_seq), .in_last(flit_last),
                .alloc(alloc_vec[g]),
                .release_go(rel_onehot[g]),
                .reserve(reserve_now),
                .rsv_src(pend_head[KEY_W-1:REQ_W]),
                .rsv_req(pend_head[REQ_W-1:0]),
                .sent(sent_vec[g]),
                .hit(hit_vec[g]), .is_free(free_vec[g]), .is_held(held_vec[g]),
                .owed(owed_vec[g]), .finish(fin_vec[g]),
                .cur_src(slot_src[g]), .cur_req(slot_req[g])
            );
        end
    endgenerate

    // Retransmit port selection
    rsm_lowest #(.N(NSLOT), .IW(SLOT_W)) u_retx_pick (
        .req(owed_vec), .any(pick_any), .idx(pick_idx)
    );

    assign sel        = lock_q ? sel_q : pick_idx;
    assign retx_valid = pick_any;
    assign retx_src   = slot_src[sel];
    assign retx_req   = slot_req[sel];
    assign lock_d     = retx_valid && !retx_ready;

    // Completion report
    rsm_lowest #(.N(NSLOT), .IW(SLOT_W)) u_fin_pick (
        .req(fin_vec), .any(fin_any), .idx(fin_idx)
    );

    always_comb begin
        dv_d   = fin_any;
        ds_d   = fin_idx;
        dsrc_d = flit_src;
        dreq_d = flit_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            sel_q  <= '0;
            dv_q   <= 1'b0;
            ds_q   <= '0;
            dsrc_q <= '0;
            dreq_q <= '0;
        end else begin
            lock_q <= lock_d;
            sel_q  <= sel;
            dv_q   <= dv_d;
            ds_q   <= ds_d;
            dsrc_q <= dsrc_d;
            dreq_q <= dreq_d;
        end
    end

    assign done_valid = dv_q;
    assign done_slot  = ds_q;
    assign done_src   = dsrc_q;
    assign done_req   = dreq_q;
endmodule

// File: rtl/rsm_chk.sv
`timescale 1ns/1ps
module rsm_chk #(
    parameter int NSLOT  = 4,
    parameter int SRC_W  = 4,
    parameter int REQ_W  = 3,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSLOT-1:0]  free_vec,
    input logic [NSLOT-1:0]  hit_vec,
    input logic              pend_empty,
    input logic              done_valid,
    input logic [SLOT_W-1:0] done_slot,
    input logic              retx_valid,
    input logic              retx_ready,
    input logic [SRC_W-1:0]  retx_src,
    input logic [REQ_W-1:0]  retx_req
);
    // R5
    pend_blocks_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_empty |-> (free_vec == '0));

    // R2
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_vec) <= 1);

    // R8
    retx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retx_valid && !retx_ready) |=> (retx_valid && $stable(retx_src) && $stable(retx_req)));

    // R2
    done_slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !free_vec[done_slot]);
endmodule

bind rtx_once_rx rsm_chk #(
    .NSLOT(NSLOT), .SRC_W(SRC_W), .REQ_W(REQ_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .free_vec(free_vec), .hit_vec(hit_vec), .pend_empty(pend_empty),
    .done_valid(done_valid), .done_slot(done_slot),
    .retx_valid(retx_valid), .retx_ready(retx_ready),
    .retx_src(retx_src), .retx_req(retx_req)
);

// File: tb/sim_rtx_once_rx.sv
`timescale 1ns/1ps
module sim_rtx_once_rx;
    localparam int NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flit_valid = 1'b0;
    logic [3:0] flit_src = '0;
    logic [2:0] flit_req = '0;
    logic [1:0] flit_seq = '0;
    logic [1:0] flit_last = '0;
    logic       rel_valid = 1'b0;
    logic [1:0] rel_slot = '0;
    logic       retx_ready = 1'b0;
    logic       done_valid, retx_valid;
    logic [1:0] done_slot;
    logic [3:0] done_src, retx_src;
    logic [2:0] done_req, retx_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtx_once_rx u0 (
        .clk(clk), .rst_n(rst_n),
        .flit_valid(flit_valid), .flit_src(flit_src), .flit_req(flit_req),
        .flit_seq(flit_seq), .flit_last(flit_last),
        .rel_valid(rel_valid), .rel_slot(rel_slot),
        .done_valid(done_valid), .done_slot(done_slot),
        .done_src(done_src), .done_req(done_req),
        .retx_valid(retx_valid), .retx_ready(retx_ready),
        .retx_src(retx_src), .retx_req(retx_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: 0 free, 1 filling, 2 waiting, 3 held
    int m_st [NS];
    int m_key [NS];
    int m_mask [NS];
    bit m_owed [NS];
    int pend[$];
    bit exp_dv = 0;
    int exp_ds = 0, exp_dk = 0;
    bit cap_fire = 0;
    int cap_key = 0;

    int done_cnt [128];
    int done_at [128];
    int fire_cnt [128];

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_st[i] = 0; m_key[i] = 0; m_mask[i] = 0; m_owed[i] = 0;
        end
        for (int k = 0; k < 128; k++) begin
            done_cnt[k] = 0; done_at[k] = -1; fire_cnt[k] = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_st[i] = 0; m_mask[i] = 0; m_owed[i] = 0;
            end
            pend.delete();
            exp_dv = 0;
        end else begin
            int k, hit, fr, rs, full;
            bit rel_ok, inp;
            k = int'(flit_src) * 8 + int'(flit_req);
            rs = int'(rel_slot);
            rel_ok = rel_valid && m_st[rs] == 3 && !m_owed[rs];
            hit = -1;
            for (int i = 0; i < NS; i++)
                if (m_st[i] != 0 && m_key[i] == k) hit = i;
            inp = 0;
            foreach (pend[j]) if (pend[j] == k) inp = 1;
            fr = -1;
            for (int i = NS - 1; i >= 0; i--)
                if (m_st[i] == 0 || (rel_ok && i == rs && pend.size() == 0)) fr = i;
            full = (2 << int'(flit_last)) - 1;
            exp_dv = 0;
            if (cap_fire)
                for (int i = 0; i < NS; i++)
                    if (m_owed[i] && m_key[i] == cap_key) m_owed[i] = 0;
            if (rel_ok) begin
                if (pend.size() > 0) begin
                    m_key[rs] = pend.pop_front();
                    m_st[rs] = 2; m_mask[rs] = 0; m_owed[rs] = 1;
                end else begin
                    m_st[rs] = 0; m_mask[rs] = 0;
                end
            end
            if (flit_valid) begin
                if (hit >= 0) begin
                    if (m_st[hit] == 1 || m_st[hit] == 2) begin
                        m_mask[hit] |= (1 << int'(flit_seq));
                        m_st[hit] = 1;
                        if (m_mask[hit] == full) begin
                            m_st[hit] = 3; exp_dv = 1; exp_ds = hit; exp_dk = k;
                        end
                    end
                end else if (!inp) begin
                    if (fr >= 0) begin
                        m_key[fr] = k; m_mask[fr] = (1 << int'(flit_seq)); m_st[fr] = 1;
                        if (m_mask[fr] == full) begin
                            m_st[fr] = 3; exp_dv = 1; exp_ds = fr; exp_dk = k;
                        end
                    end else if (pend.size() < 4) begin
                        pend.push_back(k);
                    end
                end
            end
        end
    end

    // Per-clock comparison and monitoring, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit any_owed, match;
            int rk;
            chk(done_valid == exp_dv, "R2 done_valid vs model", done_valid, exp_dv);
            if (exp_dv && done_valid) begin
                chk(int'(done_slot) == exp_ds, "R2 done_slot vs model", done_slot, exp_ds);
                chk(int'(done_src) * 8 + int'(done_req) == exp_dk, "R2 done key vs model",
                    int'(done_src) * 8 + int'(done_req), exp_dk);
            end
            any_owed = 0;
            for (int i = 0; i < NS; i++) if (m_owed[i]) any_owed = 1;
            chk(retx_valid == any_owed, "R5 retx_valid vs model", retx_valid, any_owed);
            rk = int'(retx_src) * 8 + int'(retx_req);
            if (retx_valid) begin
                match = 0;
                for (int i = 0; i < NS; i++) if (m_owed[i] && m_key[i] == rk) match = 1;
                chk(match, "R5 retx key owed in model", rk, 1);
            end
            if (done_valid) begin
                done_cnt[int'(done_src) * 8 + int'(done_req)]++;
                done_at[int'(done_src) * 8 + int'(done_req)] = int'(done_slot);
            end
            cap_fire = retx_valid && retx_ready;
            cap_key = rk;
            if (cap_fire) fire_cnt[rk]++;
        end else begin
            cap_fire = 0;
        end
    end

    task automatic drive(input bit fv, input int src, input int req, input int seq,
                         input int last, input bit rv, input int rs);
        @(posedge clk); #1;
        flit_valid = fv;
        flit_src = 4'(src); flit_req = 3'(req);
        flit_seq = 2'(seq); flit_last = 2'(last);
        rel_valid = rv; rel_slot = 2'(rs);
    endtask

    task automatic flit(input int src, input int req, input int seq, input int last);
        drive(1, src, req, seq, last, 0, 0);
    endtask

    task automatic rel(input int rs);
        drive(0, 0, 0, 0, 0, 1, rs);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int held_src;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(done_valid == 0, "R1 done_valid after reset", done_valid, 0);
        chk(retx_valid == 0, "R1 retx_valid after reset", retx_valid, 0);

        // R2: four flits out of order into slot 0
        flit(1, 1, 2, 3); flit(1, 1, 0, 3); flit(1, 1, 3, 3); flit(1, 1, 1, 3);
        idle(1); @(negedge clk);
        chk(done_valid && done_slot == 0 && done_src == 1, "R2 packet A in slot 0", done_slot, 0);

        // R3: single-flit packet reported in the next cycle
        flit(2, 2, 0, 0); idle(1); @(negedge clk);
        chk(done_valid && done_slot == 1 && done_src == 2, "R3 single flit slot 1", done_slot, 1);

        flit(3, 3, 1, 1); flit(3, 3, 0, 1);
        flit(4, 4, 0, 2); flit(4, 4, 2, 2); flit(4, 4, 1, 2);
        idle(2);
        chk(done_at[3 * 8 + 3] == 2, "R2 packet C slot", done_at[3 * 8 + 3], 2);
        chk(done_at[4 * 8 + 4] == 3, "R2 packet D slot", done_at[4 * 8 + 4], 3);

        // R9: duplicate flit of a held packet is absorbed
        flit(2, 2, 0, 0); idle(2);
        chk(done_cnt[2 * 8 + 2] == 1, "R9 held packet reported once", done_cnt[2 * 8 + 2], 1);

        // R4: all slots held, E and F dropped
        flit(5, 0, 0, 1); flit(5, 0, 1, 1); flit(6, 1, 1, 1);
        idle(2); @(negedge clk);
        chk(done_cnt[5 * 8 + 0] == 0, "R4 dropped packet not completed", done_cnt[40], 0);
        chk(retx_valid == 0, "R4 no retransmit before release", retx_valid, 0);

        // R5: release slot 1 reserves it for E, request held while stalled
        rel(1); idle(1); @(negedge clk);
        chk(retx_valid && retx_src == 5 && retx_req == 0, "R5 retransmit for oldest", retx_src, 5);
        held_src = int'(retx_src);
        idle(3); @(negedge clk);
        chk(retx_valid && int'(retx_src) == held_src, "R8 request stable under stall", retx_src, held_src);

        // new packet G still dropped: reserved slot is not free
        flit(7, 2, 0, 0); idle(1);
        chk(done_cnt[7 * 8 + 2] == 0, "R5 reserved slot not taken", done_cnt[58], 0);
        @(posedge clk); #1 retx_ready = 1'b1;
        @(posedge clk); #1 retx_ready = 1'b0;

        // R6: E resent into slot 1
        flit(5, 0, 1, 1); flit(5, 0, 0, 1); idle(2);
        chk(done_at[40] == 1, "R6 resent packet completes in reserved slot", done_at[40], 1);

        rel(0); rel(2);
        @(posedge clk); #1 retx_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 retx_ready = 1'b0;
        chk(fire_cnt[6 * 8 + 1] == 1, "R5 F request handed off", fire_cnt[49], 1);

        // R7: release of a slot still filling is ignored
        flit(6, 1, 0, 1); rel(0); flit(6, 1, 1, 1); idle(2);
        chk(done_at[49] == 0, "R7 premature release ignored", done_at[49], 0);
        flit(7, 2, 0, 0); idle(2);
        chk(done_at[58] == 2, "R6 G completes in slot 2", done_at[58], 2);

        // R10: release and new packet in the same cycle
        drive(1, 8, 3, 0, 0, 1, 3); idle(2);
        chk(done_at[8 * 8 + 3] == 3, "R10 new packet takes released slot", done_at[67], 3);

        // R11: one request per dropped packet
        chk(fire_cnt[40] == 1, "R11 single request for E", fire_cnt[40], 1);
        chk(fire_cnt[58] == 1, "R11 single request for G", fire_cnt[58], 1);

        rel(0); rel(1); rel(2); rel(3); idle(4);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule